// File: doc/BRIEF.md
# Dual-Counter Frequency Ratio Meter

This block compares the rate of one pulse source with the rate of another. Two asynchronous source inputs are synchronized into the system clock domain, and a rising edge on each produces a single-cycle count pulse. Each count pulse feeds one of two 16-bit counters. The second counter is the window counter: it closes the measurement after a programmable power-of-two number of its own counts. At that point both counters freeze and a done flag is raised. The value the first counter holds then gives the ratio of the two rates.

A host writes one 8-bit control register, which it cannot read back. This register holds the window length, the routing of the two sources, the enable, a hold-at-zero for counter 1, a hold-at-all-ones for both counters, and the choice of which counter the read port shows. The read port returns the selected counter one byte at a time. A byte address picks the low or the high half.

Top module: `freq_ratio_meter`

## Requirements
- R1: A rising edge on a routed source input that is sampled at clock edge k advances its counter by one at clock edge k+2, provided counting is active at that time. Counting is active when enable (bit 2) is 1, the done flag is 0 and the preset bit (bit 0) is 0.
- R2: Control bit 3 is an active-low swap. At 1, srcA drives counter 1 and srcB drives counter 2. At 0, srcA drives counter 2 and srcB drives counter 1.
- R3: Bits 6:4 hold a tap code k, and the window is 2^(2k+1) counter-2 increments. On the increment that completes the window, done rises in the same clock edge. After that, both counters hold their values until a write sets enable.
- R4: A control write with bit 2 set clears done and restarts the window count from zero at the edge of the write.
- R5: With bit 2 at 0, no source edge changes either counter.
- R6: While bit 7 is 1, counter 1 is held at zero. Counter 2 goes on counting.
- R7: While bit 0 is 1, both counters are held at 16'hFFFF. This preset wins over the bit 7 clear and over counting.
- R8: Counters wrap from 16'hFFFF to zero. The window is measured in increments since enable, so after a preset the window ends with counter 2 at 2^(2k+1)-1.
- R9: The read port shows counter 1 when bit 1 is 0 and counter 2 when bit 1 is 1. rdAddr 0 returns bits 7:0 and rdAddr 1 returns bits 15:8.
- R10: During and after reset, the control register, both counters and done are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| srcA | input | 1 | First measured source, asynchronous |
| srcB | input | 1 | Second measured source, asynchronous |
| wrEn | input | 1 | Control register write strobe |
| wrData | input | 8 | Control register write value |
| rdAddr | input | 1 | Byte select of the read port |
| rdData | output | 8 | Selected byte of the selected counter |
| done | output | 1 | Measurement window complete |

## Verification
The window is run at every tap code from a preset of all ones, with one source toggling every cycle and the other held quiet. The final count of the window counter therefore shows the stop length and the wrap together. Free-running sources at different rates, tried with the swap bit at each value, show which counter each input reaches. A burst of exactly counted pulses on one input gives distinct high and low bytes, which tells the byte order and the counter select apart. The hold, clear and preset bits are then applied while both inputs are active, so each priority rule is tested against live counting.

// File: rtl/frm_pkg.sv
package frm_pkg;

  localparam int TAP_W = 3;

  // control register layout, bit 7 down to bit 0
  typedef struct packed {
    logic             clr1;
    logic [TAP_W-1:0] tap;
    logic             swapN;
    logic             en;
    logic             sel;
    logic             preset;
  } ctrl_t;

  // strobes from the control module to the datapath
  typedef struct packed {
    logic inc1;
    logic inc2;
    logic forceOnes;
    logic clear1;
    logic sel;
  } strobe_t;

endpackage

// File: rtl/frm_edge_det.sv
module frm_edge_det #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic pulse
);
  localparam int LAST = STAGES;

  logic [LAST:0] shiftQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) shiftQ <= '0;
    else       shiftQ <= {shiftQ[LAST-1:0], din};
  end

  // rising edge seen between the last sync stage and the history stage
  assign pulse = shiftQ[LAST-1] & ~shiftQ[LAST];
endmodule

// File: rtl/frm_ctrl.sv
module frm_ctrl
  import frm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic [7:0]  wrData,
  input  logic        pulseA,
  input  logic        pulseB,
  output ctrl_t       ctrlQ,
  output logic        done,
  output strobe_t     strb
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] winCnt;
  logic [CNT_W-1:0] stopM1;
  logic             route1, route2;
  logic             active;
  logic             startWr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     ctrlQ <= '0;
    else if (wrEn) ctrlQ <= ctrl_t'(wrData);
  end

  assign startWr = wrEn & wrData[2];

  // window length minus one: 2^(2k+1) - 1
  assign stopM1 = (ONE << {ctrlQ.tap, 1'b1}) - ONE;

  always_comb begin
    if (ctrlQ.swapN) begin
      route1 = pulseA;
      route2 = pulseB;
    end else begin
      route1 = pulseB;
      route2 = pulseA;
    end
  end

  assign active = ctrlQ.en & ~done & ~ctrlQ.preset;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      winCnt <= '0;
      done   <= 1'b0;
    end else if (startWr) begin
      winCnt <= '0;
      done   <= 1'b0;
    end else if (active && route2) begin
      winCnt <= winCnt + ONE;
      if (winCnt == stopM1) done <= 1'b1;
    end
  end

  always_comb begin
    strb.inc1      = active & route1;
    strb.inc2      = active & route2;
    strb.forceOnes = ctrlQ.preset;
    strb.clear1    = ctrlQ.clr1;
    strb.sel       = ctrlQ.sel;
  end
endmodule

// File: rtl/frm_datapath.sv
module frm_datapath
  import frm_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [7:0]        rdData,
  output logic [CNT_W-1:0]  cnt1Q,
  output logic [CNT_W-1:0]  cnt2Q
);
  localparam int NCNT = 2;
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] cntQ [NCNT];
  logic [NCNT-1:0]  incVec;
  logic [NCNT-1:0]  clrVec;
  logic [CNT_W-1:0] selVal;

  assign incVec = {strb.inc2, strb.inc1};
  assign clrVec = {1'b0, strb.clear1};

  for (genvar i = 0; i < NCNT; i++) begin : g_cnt
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)               cntQ[i] <= '0;
      else if (strb.forceOnes) cntQ[i] <= '1;
      else if (clrVec[i])      cntQ[i] <= '0;
      else if (incVec[i])      cntQ[i] <= cntQ[i] + ONE;
    end
  end

  assign cnt1Q  = cntQ[0];
  assign cnt2Q  = cntQ[1];
  assign selVal = strb.sel ? cntQ[1] : cntQ[0];
  assign rdData = selVal[{rdAddr, 3'b000} +: 8];
endmodule

// File: rtl/freq_ratio_meter.sv
module freq_ratio_meter
  import frm_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       srcA,
  input  logic       srcB,
  input  logic       wrEn,
  input  logic [7:0] wrData,
  input  logic       rdAddr,
  output logic [7:0] rdData,
  output logic       done
);
  localparam int NSRC = 2;

  logic [NSRC-1:0]  srcVec;
  logic [NSRC-1:0]  pulseVec;
  ctrl_t            ctrlQ;
  strobe_t          strb;
  logic [CNT_W-1:0] cnt1Q, cnt2Q;

  assign srcVec = {srcB, srcA};

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    frm_edge_det #(.STAGES(SYNC_STAGES)) u_edge (
      .clk   (clk),
      .rstN  (rstN),
      .din   (srcVec[i]),
      .pulse (pulseVec[i])
    );
  end

  frm_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .wrEn   (wrEn),
    .wrData (wrData),
    .pulseA (pulseVec[0]),
    .pulseB (pulseVec[1]),
    .ctrlQ  (ctrlQ),
    .done   (done),
    .strb   (strb)
  );

  frm_datapath #(.CNT_W(CNT_W), .ADDR_W(1)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .rdAddr (rdAddr),
    .rdData (rdData),
    .cnt1Q  (cnt1Q),
    .cnt2Q  (cnt2Q)
  );
endmodule

// File: rtl/frm_checker.sv
module frm_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             wrEn,
  input logic [7:0]       wrData,
  input logic [7:0]       ctrlBits,
  input logic [CNT_W-1:0] cnt1Q,
  input logic [CNT_W-1:0] cnt2Q,
  input logic             done
);
  // R7: preset forces both counters to all ones
  a_r7_preset_ones: assert property (@(posedge clk) disable iff (!rstN)
    ctrlBits[0] |=> (cnt1Q == '1 && cnt2Q == '1));

  // R6: clear holds counter 1 at zero unless preset wins
  a_r6_clear_zero: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlBits[7] && !ctrlBits[0]) |=> (cnt1Q == '0));

  // R5: disabled counters do not move
  a_r5_disabled_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrlBits[2] && !ctrlBits[0] && !ctrlBits[7]) |=> ($stable(cnt1Q) && $stable(cnt2Q)));

  // R3: finished window freezes both counters
  a_r3_frozen: assert property (@(posedge clk) disable iff (!rstN)
    (done && !ctrlBits[0] && !ctrlBits[7]) |=> ($stable(cnt1Q) && $stable(cnt2Q)));

  // R3: done stays until an enabling write
  a_r3_done_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (done && !(wrEn && wrData[2])) |=> done);

  // R4: an enabling write clears done
  a_r4_done_clear: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrData[2]) |=> !done);
endmodule

bind freq_ratio_meter frm_checker #(.CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .wrEn     (wrEn),
  .wrData   (wrData),
  .ctrlBits (ctrlQ),
  .cnt1Q    (cnt1Q),
  .cnt2Q    (cnt2Q),
  .done     (done)
);

// File: tb/sim_freq_ratio_meter.sv
module sim_freq_ratio_meter;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       srcA = 1'b0, srcB = 1'b0;
  logic       wrEn = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic       rdAddr = 1'b0;
  logic [7:0] rdData;
  logic       done;

  always #(CLK_PERIOD/2) clk = ~clk;

  freq_ratio_meter u0 (
    .clk(clk), .rstN(rstN), .srcA(srcA), .srcB(srcB),
    .wrEn(wrEn), .wrData(wrData), .rdAddr(rdAddr),
    .rdData(rdData), .done(done)
  );

  int    nCmp = 0, nBad = 0;
  string phase = "R10";
  int    halfA = 0, halfB = 0;
  int    reqA = 0, sentA = 0;
  bit    autoRd = 1'b1;
  bit    finished = 1'b0;

  // ---------------- reference model ----------------
  logic [2:0]  mA, mB;
  logic [7:0]  mCtrl;
  logic [15:0] mC1, mC2;
  int          mWin;
  bit          mDone;

  always @(posedge clk or negedge rstN) begin : model
    logic pA, pB, p1, p2, act;
    int   stopLen;
    if (!rstN) begin
      mA <= 0; mB <= 0; mCtrl <= 0; mC1 <= 0; mC2 <= 0; mWin <= 0; mDone <= 0;
    end else begin
      pA = mA[1] && !mA[2];
      pB = mB[1] && !mB[2];
      p1 = mCtrl[3] ? pA : pB;
      p2 = mCtrl[3] ? pB : pA;
      act = mCtrl[2] && !mDone && !mCtrl[0];
      stopLen = 1 << (2 * int'(mCtrl[6:4]) + 1);
      mA <= {mA[1:0], srcA};
      mB <= {mB[1:0], srcB};
      if (mCtrl[0]) begin
        mC1 <= 16'hFFFF; mC2 <= 16'hFFFF;
      end else begin
        if (mCtrl[7]) mC1 <= 0;
        else if (act && p1) mC1 <= mC1 + 16'd1;
        if (act && p2) mC2 <= mC2 + 16'd1;
      end
      if (wrEn && wrData[2]) begin
        mWin <= 0; mDone <= 0;
      end else if (act && p2) begin
        mWin <= mWin + 1;
        if (mWin + 1 == stopLen) mDone <= 1;
      end
      if (wrEn) mCtrl <= wrData;
    end
  end

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    nCmp++;
    if (got !== exp) begin
      nBad++;
      $display("FAIL %s got %0h expected %0h at %0t", tag, got, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    logic [15:0] v;
    #3;
    if (!finished) begin
      v = mCtrl[1] ? mC2 : mC1;
      check({phase, " rdData"}, {24'h0, rdData}, {24'h0, rdAddr ? v[15:8] : v[7:0]});
      check({phase, " done"}, {31'h0, done}, {31'h0, mDone});
    end
  end

  // ---------------- stimulus drivers ----------------
  int stA = 0, cntA = 0, cntB = 0;
  always @(negedge clk) begin
    if (halfA > 0) begin
      cntA++;
      if (cntA >= halfA) begin srcA <= ~srcA; cntA = 0; end
    end else if (sentA < reqA) begin
      srcA <= (stA < 2);
      stA++;
      if (stA == 4) begin stA = 0; sentA <= sentA + 1; end
    end else srcA <= 1'b0;
    if (halfB > 0) begin
      cntB++;
      if (cntB >= halfB) begin srcB <= ~srcB; cntB = 0; end
    end else srcB <= 1'b0;
    if (autoRd) rdAddr <= ~rdAddr;
  end

  function automatic logic [7:0] mk(bit clr, int tap, bit swapN, bit en, bit sel, bit pre);
    return {clr, 3'(tap), swapN, en, sel, pre};
  endfunction

  task automatic writeCtrl(logic [7:0] d);
    @(negedge clk); wrEn = 1'b1; wrData = d;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic read16(output logic [15:0] val);
    logic [7:0] lo;
    autoRd = 1'b0;
    @(posedge clk);
    #1 rdAddr = 1'b0;
    #1 lo = rdData;
    rdAddr = 1'b1;
    #1 val = {rdData, lo};
    autoRd = 1'b1;
  endtask

  task automatic pulsesA(int n);
    reqA = reqA + n;
    while (sentA < reqA) @(negedge clk);
    idle(6);
  endtask

  task automatic finish();
    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  endtask

  // watchdog
  initial begin
    repeat (190000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog expired in phase %s", phase);
    finish();
  end

  // ---------------- main sequence ----------------
  initial begin
    logic [15:0] v, w;
    idle(3);
    read16(v);
    check("R10 counter in reset", {16'h0, v}, 32'h0);
    check("R10 done in reset", {31'h0, done}, 32'h0);
    rstN = 1'b1;
    idle(3);
    read16(v);
    check("R10 counter after reset", {16'h0, v}, 32'h0);

    // R1 and R8: exact pulse count from preset wraps through zero
    phase = "R1";
    writeCtrl(mk(0, 7, 1, 0, 0, 1));
    idle(3);
    writeCtrl(mk(0, 7, 1, 1, 0, 0));
    pulsesA(5);
    read16(v);
    check("R1 five pulses from all ones", {16'h0, v}, 32'h4);

    // R9: distinct bytes and counter select
    phase = "R9";
    pulsesA(295);
    read16(v);
    check("R9 low byte", {24'h0, v[7:0]}, 32'h2B);
    check("R9 high byte", {24'h0, v[15:8]}, 32'h01);
    writeCtrl(mk(0, 7, 1, 1, 1, 0));
    read16(v);
    check("R9 select counter 2", {16'h0, v}, 32'hFFFF);

    // R2: routing with srcA free-running, srcB quiet
    phase = "R2";
    writeCtrl(mk(0, 7, 0, 0, 0, 1));
    idle(3);
    writeCtrl(mk(0, 7, 0, 1, 0, 0));
    halfA = 1;
    idle(30);
    halfA = 0;
    idle(6);
    read16(v);
    check("R2 swapped: counter 1 idle", {16'h0, v}, 32'hFFFF);
    writeCtrl(mk(0, 7, 0, 0, 1, 0));
    read16(v);
    check("R2 swapped: counter 2 counted", {31'h0, v != 16'hFFFF}, 32'h1);
    halfA = 1; halfB = 3;
    writeCtrl(mk(0, 7, 1, 1, 0, 0));
    idle(40);
    halfA = 0; halfB = 0;
    idle(6);

    // R3 and R8: every tap from a preset
    phase = "R3";
    for (int k = 0; k < 8; k++) begin
      writeCtrl(mk(0, k, 1, 0, 1, 1));
      idle(4);
      halfB = 1;
      writeCtrl(mk(0, k, 1, 1, 1, 0));
      for (int i = 0; i < 70000 && !done; i++) @(negedge clk);
      idle(8);
      read16(v);
      check($sformatf("R3 R8 tap %0d window end count", k), {16'h0, v},
            32'((1 << (2 * k + 1)) - 1));
      check($sformatf("R3 tap %0d done", k), {31'h0, done}, 32'h1);
      idle(10);
      read16(w);
      check($sformatf("R3 tap %0d frozen", k), {16'h0, w}, {16'h0, v});
      halfB = 0;
      idle(6);
    end

    // R4: enabling write clears done
    phase = "R4";
    writeCtrl(mk(0, 7, 1, 1, 1, 0));
    check("R4 done cleared", {31'h0, done}, 32'h0);

    // R5: disabled with both inputs active
    phase = "R5";
    writeCtrl(mk(0, 7, 1, 0, 0, 0));
    halfA = 1; halfB = 2;
    read16(v);
    idle(20);
    read16(w);
    check("R5 counter 1 unchanged", {16'h0, w}, {16'h0, v});
    writeCtrl(mk(0, 7, 1, 0, 1, 0));
    read16(v);
    idle(20);
    read16(w);
    check("R5 counter 2 unchanged", {16'h0, w}, {16'h0, v});

    // R6: clear counter 1 while counter 2 runs
    phase = "R6";
    writeCtrl(mk(1, 7, 1, 1, 0, 0));
    idle(10);
    read16(v);
    check("R6 counter 1 held at zero", {16'h0, v}, 32'h0);
    writeCtrl(mk(1, 7, 1, 1, 1, 0));
    read16(v);
    idle(20);
    read16(w);
    check("R6 counter 2 still counting", {31'h0, w != v}, 32'h1);

    // R7: preset over clear and counting
    phase = "R7";
    writeCtrl(mk(1, 7, 1, 1, 0, 1));
    idle(5);
    read16(v);
    check("R7 counter 1 all ones", {16'h0, v}, 32'hFFFF);
    writeCtrl(mk(1, 7, 1, 1, 1, 1));
    idle(5);
    read16(v);
    check("R7 counter 2 all ones", {16'h0, v}, 32'hFFFF);
    halfA = 0; halfB = 0;
    idle(10);
    finish();
  end
endmodule